// File: doc/BRIEF.md
# Framed Serial Word Deserializer

This block sits on the receive side of a multi-lane serial link. Each data lane and one frame line reach it already sampled in a fast clock domain, one sample per bit period. A rising edge on the frame line marks the bit period that carries bit 0 of a new word. The block gathers the following bits least significant first into parallel words, one per lane.

Once the frame line has shown a steady period of one word length, the block declares lock and publishes every completed word with a one-cycle valid strobe. Words gathered before lock are dropped. A format input states how the sender coded its samples. Offset-binary words are turned into two's complement by inverting the top bit, and two's-complement words pass through unchanged. Each lane also raises a flag when its raw received word equals the fixed test word 0x0BD. That flag lets link bring-up logic check the bit order and the word boundary.

Top module: `framed_ser_rx`

## Requirements
- R1: Lock (`locked_o`) rises in the cycle after a frame-line rising edge that arrives exactly WORD_W (12) sample cycles after the previous rising edge.
- R2: A frame-line rising edge at any other spacing from the previous one clears lock in the following cycle. The first edge after reset never sets lock.
- R3: The sample taken in the cycle of the frame-line rising edge becomes bit 0 of the word, and the k-th later sample becomes bit k, up to bit 11.
- R4: `valid_o` is high for exactly one cycle, in the cycle after the twelfth bit of a word is sampled while lock is set. Words and flags hold their values whenever `valid_o` is low.
- R5: A word whose twelfth bit is sampled while lock is clear produces no `valid_o` and leaves the outputs unchanged.
- R6: With `fmt_offset` high (offset binary) in the twelfth-bit cycle, the published word is the raw word with bit 11 inverted. With it low (two's complement), the raw word is published unchanged.
- R7: `test_hit_o[n]` is updated with each published word and is 1 exactly when lane n's raw received word, before any format conversion, equals 0x0BD.
- R8: While `rst_n` is low at a clock edge, lock, the bit counter, the spacing tracker, all words, all flags and `valid_o` are cleared.
- R9: Each lane assembles its own word from its own input bit. Lane n occupies `words_o[12n+11:12n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 4 | One sampled serial bit per lane |
| frm_in | input | 1 | Sampled frame line |
| fmt_offset | input | 1 | 1: incoming words are offset binary, 0: two's complement |
| words_o | output | 48 | Four received words, lane n at bits 12n+11:12n |
| valid_o | output | 1 | One-cycle strobe for a new set of words |
| test_hit_o | output | 4 | Per-lane raw word equals 0x0BD |
| locked_o | output | 1 | Frame spacing is locked |

## Verification
The hardest case to reach is the loss and regain of lock, with the word in flight at each transition correctly dropped or published. The stimulus sends a truncated frame. It then sends a full frame whose edge comes at the wrong spacing and must be discarded, and the following frame must be published again. An idle stretch that delays a frame edge past twelve cycles covers the late-edge case. The format input is switched between frames at the first bit, so that the conversion is checked against the word it belongs to.

// File: rtl/framed_ser_rx.sv
module framed_ser_rx #(
  parameter int LANES = 4,
  parameter int WORD_W = 12,
  parameter logic [WORD_W-1:0] TEST_WORD = 12'h0BD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        ser_in,
  input  logic                    frm_in,
  input  logic                    fmt_offset,
  output logic [LANES*WORD_W-1:0] words_o,
  output logic                    valid_o,
  output logic [LANES-1:0]        test_hit_o,
  output logic                    locked_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int GAP_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [GAP_W-1:0] GAP_OK  = GAP_W'(WORD_W);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(WORD_W + 1);

  logic             frm_q;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] gap;
  logic             seen;
  logic             lock_q;
  logic             vld_q;

  wire              edge_s   = frm_in & ~frm_q;
  wire [CNT_W-1:0]  idx      = edge_s ? '0 : cnt;
  wire              last_bit = (idx == LAST_IDX);
  wire              publish  = last_bit & lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_q  <= 1'b0;
      cnt    <= '0;
      gap    <= '0;
      seen   <= 1'b0;
      lock_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      frm_q <= frm_in;
      cnt   <= last_bit ? '0 : idx + CNT_W'(1);
      vld_q <= publish;
      if (edge_s) begin
        seen   <= 1'b1;
        gap    <= GAP_W'(1);
        lock_q <= seen && (gap == GAP_OK);
      end else if (gap != GAP_MAX) begin
        gap <= gap + GAP_W'(1);
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-2:0] sh;
    logic [WORD_W-1:0] word_q;
    logic              hit_q;
    wire  [WORD_W-1:0] raw  = {ser_in[g], sh};
    wire  [WORD_W-1:0] conv = fmt_offset ? {~raw[WORD_W-1], raw[WORD_W-2:0]} : raw;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh     <= '0;
        word_q <= '0;
        hit_q  <= 1'b0;
      end else begin
        if (!last_bit) sh[idx] <= ser_in[g];
        if (publish) begin
          word_q <= conv;
          hit_q  <= (raw == TEST_WORD);
        end
      end
    end

    assign words_o[g*WORD_W +: WORD_W] = word_q;
    assign test_hit_o[g] = hit_q;
  end

  assign valid_o  = vld_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/framed_ser_rx_chk.sv
module framed_ser_rx_chk #(
  parameter int LANES = 4,
  parameter int WORD_W = 12,
  parameter logic [WORD_W-1:0] TEST_WORD = 12'h0BD
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES-1:0]        ser_in,
  input logic                    frm_in,
  input logic                    fmt_offset,
  input logic [LANES*WORD_W-1:0] words_o,
  input logic                    valid_o,
  input logic [LANES-1:0]        test_hit_o,
  input logic                    locked_o
);
  localparam logic [WORD_W-1:0] MSB_FLIP = {1'b1, {(WORD_W-1){1'b0}}};

  assert_lock_rise_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> ($past(frm_in) && !$past(frm_in, 2)));

  assert_lock_fall_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> ($past(frm_in) && !$past(frm_in, 2)));

  assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(locked_o));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !valid_o) |-> ($stable(words_o) && $stable(test_hit_o)));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!locked_o && !valid_o && words_o == '0 && test_hit_o == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_hit_twos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(fmt_offset)) |->
        (test_hit_o[g] == (words_o[g*WORD_W +: WORD_W] == TEST_WORD)));
    assert_hit_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(fmt_offset)) |->
        (test_hit_o[g] == (words_o[g*WORD_W +: WORD_W] == (TEST_WORD ^ MSB_FLIP))));
  end
endmodule

bind framed_ser_rx framed_ser_rx_chk #(
  .LANES(LANES), .WORD_W(WORD_W), .TEST_WORD(TEST_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frm_in(frm_in),
  .fmt_offset(fmt_offset), .words_o(words_o), .valid_o(valid_o),
  .test_hit_o(test_hit_o), .locked_o(locked_o)
);

// File: tb/framed_ser_rx_tb_top.sv
module framed_ser_rx_tb_top;
  typedef struct packed {
    logic [47:0] w;
    logic [3:0]  h;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ser = '0;
  logic        frm = 1'b0;
  logic        fmt = 1'b0;
  logic [47:0] words;
  logic        valid;
  logic [3:0]  hits;
  logic        locked;

  int checks = 0;
  int fails = 0;
  bit prev_valid = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  framed_ser_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser), .frm_in(frm), .fmt_offset(fmt),
    .words_o(words), .valid_o(valid), .test_hit_o(hits), .locked_o(locked)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send_frame(input logic [11:0] w0, w1, w2, w3,
                            input int nbits, input bit expect_out, input bit fmtv);
    logic [11:0] ws[4];
    exp_t e;
    ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
    if (expect_out && nbits == 12) begin
      for (int l = 0; l < 4; l++) begin
        e.w[l*12 +: 12] = fmtv ? (ws[l] ^ 12'h800) : ws[l];
        e.h[l] = (ws[l] == 12'h0BD);
      end
      q.push_back(e);
    end
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk);
      if (b == 0) fmt <= fmtv;
      frm <= (b < 6);
      ser <= {w3[b], w2[b], w1[b], w0[b]};
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm <= 1'b0;
      ser <= '0;
    end
  endtask

  // monitor: pops expected items as the design publishes words
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        chk(!prev_valid, "R4 single-cycle valid", 48'(prev_valid), 48'(0));
        if (q.size() == 0) begin
          chk(1'b0, "R5 valid without expected word", words, 48'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(words == e.w, "R3 R6 R9 published words", words, e.w);
          chk(hits == e.h, "R7 test-word flags", 48'(hits), 48'(e.h));
        end
      end
      prev_valid = valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!locked && !valid, "R8 reset lock/valid", 48'({locked, valid}), 48'(0));
    chk(words == '0 && hits == '0, "R8 reset words/flags", words, 48'(0));
    rst_n <= 1'b1;

    // first frame: no lock yet, word dropped (R5)
    send_frame(12'h3C5, 12'h0BD, 12'h111, 12'h222, 12, 1'b0, 1'b0);
    chk(!locked, "R2 first edge gives no lock", 48'(locked), 48'(0));
    // second frame edge 12 apart: lock and publish (R1)
    send_frame(12'h0BD, 12'h123, 12'hFFF, 12'h800, 12, 1'b1, 1'b0);
    chk(locked, "R1 lock after spaced edges", 48'(locked), 48'(1));
    send_frame(12'h001, 12'h7FF, 12'hA5C, 12'h0BC, 12, 1'b1, 1'b0);
    // offset binary input (R6), raw test word still flagged (R7)
    send_frame(12'h0BD, 12'h000, 12'hFFF, 12'h7FF, 12, 1'b1, 1'b1);
    send_frame(12'h8BD, 12'h0BD, 12'h555, 12'hAAA, 12, 1'b1, 1'b1);
    // truncated frame then early edge: lock lost, word dropped (R2, R5)
    send_frame(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 7, 1'b0, 1'b0);
    chk(locked, "R1 lock kept on spaced edge", 48'(locked), 48'(1));
    send_frame(12'h0BD, 12'h0BD, 12'h0BD, 12'h0BD, 12, 1'b0, 1'b0);
    chk(!locked, "R2 early edge clears lock", 48'(locked), 48'(0));
    send_frame(12'h0BD, 12'h456, 12'h789, 12'hABC, 12, 1'b1, 1'b0);
    chk(locked, "R1 lock regained", 48'(locked), 48'(1));
    // late edge after idle: lock lost again (R2)
    idle(3);
    send_frame(12'h111, 12'h222, 12'h333, 12'h444, 12, 1'b0, 1'b0);
    chk(!locked, "R2 late edge clears lock", 48'(locked), 48'(0));
    send_frame(12'hDEF, 12'h0BD, 12'h800, 12'h7FF, 12, 1'b1, 1'b1);
    chk(locked, "R1 lock after late recovery", 48'(locked), 48'(1));
    idle(3);
    chk(q.size() == 0, "R4 all expected words published", 48'(q.size()), 48'(0));
    // R4: outputs hold after last publish
    chk(!valid, "R4 valid low when idle", 48'(valid), 48'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule